// File: doc/BRIEF.md
# Network Link Statistics Counter Bank

This block gathers running statistics for one port of a ring network interface. Everything runs on the network transmit clock. It keeps a free-running cycle timer and a timer that measures transit latency. It also counts received traffic (shared-memory data phases, interrupt packets, and traffic from one chosen node) and link faults (any error, link drops, and 8b/10b decode errors). Another counter tracks entries written into a 256-slot interrupt queue, and its low bits give the queue's next write slot.

The receive path sends single-cycle strobes into the block. A programmable hunt node ID picks which source the hunt counter follows. One synchronous clear strobe zeroes every counter at once. Software-side logic reads any counter through a registered word-addressed read port. All counters are `CNT_W` bits wide and wrap silently.

Top module: `net_stats_unit`

## Requirements
- R1: The cycle timer (address 0) advances by one on every clock edge and wraps modulo 2^CNT_W.
- R2: An `am_tx` strobe loads the latency timer (address 1) with zero and starts it. The timer then adds one per clock until an `am_native_rx` strobe arrives. The stop cycle adds nothing, and the value holds until the next start.
- R3: An `am_native_rx` strobe while the latency timer is idle is ignored. When `am_tx` and `am_native_rx` arrive in the same cycle, the start takes effect.
- R4: The shared-memory counter (address 2) adds one for every `shm_valid` strobe, whatever the value of `shm_native`.
- R5: The interrupt traffic counter (address 3) adds one for every `intr_rx` strobe.
- R6: The hunt counter (address 4) adds one only when `shm_valid` is high and `shm_src` equals `hunt_id`. Interrupt strobes never change it.
- R7: The queue counter (address 5) adds one per `intr_enq` strobe. `q_wr_slot` equals its low QPTR_W bits, so the value wraps to 0 after 256 entries.
- R8: The link error counter (address 6) adds exactly one in any cycle where at least one of these is true: a bit of `err_vec` is set (bit 0 decode, 1 sync, 2 CRC, 3 EOF, 4 protocol, 5 receive FIFO), or `link_up` falls.
- R9: The link-down counter (address 7) adds one only when `link_up` goes from 1 in one cycle to 0 in the next. It does not count the cycles the link stays down.
- R10: The decode error counter (address 8) adds one whenever `err_vec` bit 0 is set.
- R11: `clr` zeroes every counter and stops the latency timer on the next edge. It takes priority over any event in the same cycle.
- R12: `rd_data` shows the counter at `rd_addr` as it stood before the edge that samples the address, one cycle later. Unmapped addresses (9 to 15) read as zero.
- R13: After reset, every counter and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all counters |
| shm_valid | input | 1 | Shared-memory data phase received |
| shm_src | input | ID_W | Source node of the data phase |
| shm_native | input | 1 | Data phase is native (1) or foreign (0) |
| intr_rx | input | 1 | Network interrupt packet received |
| intr_enq | input | 1 | Interrupt written into the queue |
| err_vec | input | 6 | Error strobes: decode, sync, CRC, EOF, protocol, RX FIFO |
| link_up | input | 1 | Link status level |
| am_tx | input | 1 | Auto-message transmitted |
| am_native_rx | input | 1 | Native auto-message received |
| hunt_id | input | ID_W | Node followed by the hunt counter |
| rd_addr | input | ADDR_W | Counter word address |
| rd_data | output | CNT_W | Registered read data |
| q_wr_slot | output | QPTR_W | Next interrupt queue write slot |

## Verification
The assertions assume that `clr` is the only thing that resets a counter. Between clears, `link_up` is a clean level, and event strobes are treated as per-cycle facts, so a strobe held high is counted once per cycle. The stimulus applies every strobe for whole cycles only, never touches inputs during reset, and keeps strobes low while it reads results. This keeps the traffic counters static during a read. The cycle timer is the one exception, and its expected value is computed from the number of edges.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  localparam int NUM_CNT  = 9;
  localparam int ERR_BITS = 6;

  // counter word addresses
  localparam int A_NET  = 0;
  localparam int A_LAT  = 1;
  localparam int A_SHM  = 2;
  localparam int A_INTR = 3;
  localparam int A_HUNT = 4;
  localparam int A_QUE  = 5;
  localparam int A_LERR = 6;
  localparam int A_LDN  = 7;
  localparam int A_DEC  = 8;

  // error strobe bit positions
  localparam int E_DEC   = 0;
  localparam int E_SYNC  = 1;
  localparam int E_CRC   = 2;
  localparam int E_EOF   = 3;
  localparam int E_PROTO = 4;
  localparam int E_RXF   = 5;
endpackage

// File: rtl/nsu_counter.sv
module nsu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/nsu_latency.sv
module nsu_latency #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         stop,
  output logic [W-1:0] q
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q     <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      q     <= '0;
      run_q <= 1'b1;
    end else if (run_q && stop) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      q <= q + 1'b1;
    end
  end

  // R2
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !start && !run_q) |=> $stable(q));

  // R3
  lat_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && start) |=> (q == '0 && run_q));
endmodule

// File: rtl/nsu_evt_decode.sv
module nsu_evt_decode
  import nsu_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shm_valid,
  input  logic [ID_W-1:0]     shm_src,
  input  logic                intr_rx,
  input  logic                intr_enq,
  input  logic [ERR_BITS-1:0] err_vec,
  input  logic                link_up,
  input  logic [ID_W-1:0]     hunt_id,
  output logic [NUM_CNT-1:0]  inc_vec
);
  logic link_up_q;
  logic link_fall;

  always_ff @(posedge clk) begin
    if (rst) link_up_q <= 1'b0;
    else     link_up_q <= link_up;
  end

  assign link_fall = link_up_q && !link_up;

  always_comb begin
    inc_vec         = '0;
    inc_vec[A_NET]  = 1'b1;
    inc_vec[A_SHM]  = shm_valid;
    inc_vec[A_INTR] = intr_rx;
    inc_vec[A_HUNT] = shm_valid && (shm_src == hunt_id);
    inc_vec[A_QUE]  = intr_enq;
    inc_vec[A_LERR] = (|err_vec) || link_fall;
    inc_vec[A_LDN]  = link_fall;
    inc_vec[A_DEC]  = err_vec[E_DEC];
  end

  // R6
  hunt_needs_shm_chk: assert property (@(posedge clk) disable iff (rst)
    inc_vec[A_HUNT] |-> inc_vec[A_SHM]);

  // R9
  down_implies_err_chk: assert property (@(posedge clk) disable iff (rst)
    inc_vec[A_LDN] |-> inc_vec[A_LERR]);
endmodule

// File: rtl/nsu_read_port.sv
module nsu_read_port
  import nsu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [CNT_W-1:0]                rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int i = 0; i < NUM_CNT; i++) begin
        if (rd_addr == ADDR_W'(i)) rd_data <= cnt_all[i];
      end
    end
  end

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= ADDR_W'(NUM_CNT)) |=> (rd_data == '0));
endmodule

// File: rtl/net_stats_unit.sv
module net_stats_unit
  import nsu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ID_W   = 8,
  parameter int QPTR_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                shm_valid,
  input  logic [ID_W-1:0]     shm_src,
  input  logic                shm_native,
  input  logic                intr_rx,
  input  logic                intr_enq,
  input  logic [ERR_BITS-1:0] err_vec,
  input  logic                link_up,
  input  logic                am_tx,
  input  logic                am_native_rx,
  input  logic [ID_W-1:0]     hunt_id,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  output logic [QPTR_W-1:0]   q_wr_slot
);
  logic [NUM_CNT-1:0]            inc_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic                          unused_native;

  // native/foreign does not alter counting
  assign unused_native = shm_native;

  nsu_evt_decode #(.ID_W(ID_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .shm_valid(shm_valid),
    .shm_src  (shm_src),
    .intr_rx  (intr_rx),
    .intr_enq (intr_enq),
    .err_vec  (err_vec),
    .link_up  (link_up),
    .hunt_id  (hunt_id),
    .inc_vec  (inc_vec)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == A_LAT) begin : g_lat
      nsu_latency #(.W(CNT_W)) u_lat (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .start(am_tx),
        .stop (am_native_rx),
        .q    (cnt_all[i])
      );
    end else begin : g_plain
      nsu_counter #(.W(CNT_W)) u_cnt (
        .clk(clk),
        .rst(rst),
        .clr(clr),
        .inc(inc_vec[i]),
        .q  (cnt_all[i])
      );
    end
  end

  assign q_wr_slot = cnt_all[A_QUE][QPTR_W-1:0];

  nsu_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .cnt_all(cnt_all),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // R1
  net_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_all[A_NET] == CNT_W'($past(cnt_all[A_NET]) + 1'b1));

  // R8
  err_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> CNT_W'(cnt_all[A_LERR] - $past(cnt_all[A_LERR])) <= CNT_W'(1));

  // R9
  down_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && link_up) |=> $stable(cnt_all[A_LDN]));

  // R6
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !shm_valid) |=> $stable(cnt_all[A_HUNT]));

  // R11
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_all[A_SHM] == '0 && cnt_all[A_LERR] == '0 && cnt_all[A_NET] == '0));
endmodule

// File: tb/net_stats_unit_tb.sv
module net_stats_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        clr;
  logic        shm_valid;
  logic [7:0]  shm_src;
  logic        shm_native;
  logic        intr_rx;
  logic        intr_enq;
  logic [5:0]  err_vec;
  logic        link_up;
  logic        am_tx;
  logic        am_native_rx;
  logic [7:0]  hunt_id;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  q_wr_slot;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_stats_unit u_dut (
    .clk(clk), .rst(rst), .clr(clr), .shm_valid(shm_valid), .shm_src(shm_src),
    .shm_native(shm_native), .intr_rx(intr_rx), .intr_enq(intr_enq),
    .err_vec(err_vec), .link_up(link_up), .am_tx(am_tx),
    .am_native_rx(am_native_rx), .hunt_id(hunt_id), .rd_addr(rd_addr),
    .rd_data(rd_data), .q_wr_slot(q_wr_slot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_cnt(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R13 rd_data after reset", rd_data, 32'd0);
    for (int a = 1; a < 9; a++) begin
      read_cnt(a[3:0], v);
      check("R13 counter zero after reset", v, 32'd0);
    end
    check("R13 q_wr_slot after reset", {24'd0, q_wr_slot}, 32'd0);
  endtask

  task automatic test_net_timer();
    @(negedge clk);
    clr = 1'b1;
    rd_addr = 4'd0;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R1 cycle timer count", rd_data, 32'd9);
    @(posedge clk);
    @(negedge clk);
    check("R1 cycle timer next", rd_data, 32'd10);
  endtask

  task automatic test_latency();
    logic [31:0] v;
    do_clear();
    @(negedge clk); am_native_rx = 1'b1; @(posedge clk); @(negedge clk); am_native_rx = 1'b0;
    idle(3);
    read_cnt(4'd1, v);
    check("R3 stop without start ignored", v, 32'd0);
    @(negedge clk); am_tx = 1'b1; @(posedge clk); @(negedge clk); am_tx = 1'b0;
    idle(7) ;
    // idle(7) above consumed 7 edges then a negedge; stop now
    am_native_rx = 1'b1; @(posedge clk); @(negedge clk); am_native_rx = 1'b0;
    idle(5);
    read_cnt(4'd1, v);
    check("R2 latency transit cycles", v, 32'd7);
    @(negedge clk); am_tx = 1'b1; am_native_rx = 1'b1;
    @(posedge clk); @(negedge clk); am_tx = 1'b0; am_native_rx = 1'b0;
    am_native_rx = 1'b1; @(posedge clk); @(negedge clk); am_native_rx = 1'b0;
    read_cnt(4'd1, v);
    check("R3 start wins over simultaneous stop", v, 32'd0);
    @(negedge clk); am_tx = 1'b1; @(posedge clk); @(negedge clk); am_tx = 1'b0;
    idle(2);
    do_clear();
    idle(4);
    read_cnt(4'd1, v);
    check("R11 clear stops latency timer", v, 32'd0);
  endtask

  task automatic test_traffic();
    logic [31:0] v;
    do_clear();
    @(negedge clk);
    hunt_id = 8'h2A;
    for (int k = 0; k < 5; k++) begin
      shm_valid  = 1'b1;
      shm_src    = (k < 3) ? 8'h2A : 8'h11;
      shm_native = k[0];
      intr_rx    = (k != 4);
      @(posedge clk); @(negedge clk);
    end
    shm_valid = 1'b0; intr_rx = 1'b0;
    read_cnt(4'd2, v); check("R4 shared-memory phases", v, 32'd5);
    read_cnt(4'd3, v); check("R5 interrupt packets", v, 32'd4);
    read_cnt(4'd4, v); check("R6 hunt matches only", v, 32'd3);
    @(negedge clk); clr = 1'b1; shm_valid = 1'b1; shm_src = 8'h2A;
    @(posedge clk); @(negedge clk); clr = 1'b0; shm_valid = 1'b0;
    read_cnt(4'd2, v); check("R11 clear wins over event", v, 32'd0);
    read_cnt(4'd4, v); check("R11 hunt cleared", v, 32'd0);
  endtask

  task automatic test_queue();
    logic [31:0] v;
    do_clear();
    @(negedge clk);
    intr_enq = 1'b1;
    repeat (256) @(posedge clk);
    @(negedge clk);
    check("R7 slot wraps at 256", {24'd0, q_wr_slot}, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    intr_enq = 1'b0;
    check("R7 slot after 260", {24'd0, q_wr_slot}, 32'd4);
    read_cnt(4'd5, v); check("R7 queue count", v, 32'd260);
  endtask

  task automatic test_errors();
    logic [31:0] v;
    do_clear();
    @(negedge clk);
    err_vec = 6'b111111; link_up = 1'b0;
    @(posedge clk); @(negedge clk);
    err_vec = 6'b0;
    idle(3);
    link_up = 1'b1;
    @(posedge clk); @(negedge clk);
    err_vec = 6'b000010;
    @(posedge clk); @(negedge clk);
    err_vec = 6'b0; link_up = 1'b0;
    @(posedge clk); @(negedge clk);
    link_up = 1'b1;
    idle(2);
    read_cnt(4'd6, v); check("R8 link error merged count", v, 32'd3);
    read_cnt(4'd7, v); check("R9 link-down transitions", v, 32'd2);
    read_cnt(4'd8, v); check("R10 decode errors", v, 32'd1);
    read_cnt(4'd9, v); check("R12 unmapped address 9", v, 32'd0);
    read_cnt(4'd15, v); check("R12 unmapped address 15", v, 32'd0);
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; shm_valid = 1'b0; shm_src = '0; shm_native = 1'b0;
    intr_rx = 1'b0; intr_enq = 1'b0; err_vec = '0; link_up = 1'b1;
    am_tx = 1'b0; am_native_rx = 1'b0; hunt_id = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_net_timer();
    test_latency();
    test_traffic();
    test_queue();
    test_errors();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule